// File: doc/BRIEF.md
# Scalable Memory-Mapped System Counter

This block keeps a 64-bit system count. It advances on qualified input ticks, either by exactly one or by a programmable fixed-point step. Two register frames sit on a simple 32-bit request interface. The control frame holds the run controls and the step register, and lets software read or overwrite either 32-bit half of the count. The status frame is a read-only view of the count for observers that must not disturb it. Both frames carry a table of identification bytes.

The run mode is a three-state machine held in the control path:

- ST_HALT: the count holds.
- ST_UNIT: each tick adds 1.
- ST_SCALED: each tick adds the step register, read as an unsigned 8.24 value. A 24-bit fraction accumulator carries the remainder from one tick to the next.

Transitions happen only on a write to the control register:

- GO_HALT: the enable bit is written 0, from any state.
- GO_UNIT: enable is written 1 and scale-enable 0.
- GO_SCALED: enable is written 1 and scale-enable 1.

A write that repeats the current mode stays put. Reset enters ST_HALT.

Top module: `system_counter`

## Requirements
- R1: After reset the control register reads 0, both count halves read 0, `count_o` is 0 and the step register reads 0x01000000.
- R2: A control write (control offset 0x00) keeps only bits 4:0: bit 0 enable, bit 1 debug-halt, bit 2 scale-enable, bit 3 interrupt mask, bit 4 error-response disable. Bit 5 and above read back as 0.
- R3: In ST_HALT the count does not change, whatever the tick input does.
- R4: In ST_UNIT each cycle with `tick` high adds exactly 1 to the count. A cycle without `tick` leaves it unchanged.
- R5: In ST_SCALED each tick adds step/2^24 to the count. The leftover fraction is kept between ticks. With step 0x00800000, two ticks add 1; with step 0x01800000, three ticks from a clean fraction add 4.
- R6: A write to control offset 0x08 replaces count bits 31:0, and a write to 0x0C replaces bits 63:32. The other half keeps its value, and the fraction is cleared. A count write wins over a tick in the same cycle. The count wraps from all ones to 0.
- R7: Control offsets 0x10 and 0xD0 both access the one step register. Offset 0xD4 reads 0 and ignores writes. Offset 0x04 reads 0.
- R8: Control offset 0x1C reads 0x00020001, which is 1 in bits 18:17 and 1 in bits 3:0, and ignores writes.
- R9: Control offsets 0xFD0 to 0xFFC, one word per byte, read 04,00,00,00,BA,B0,0B,00,0D,F0,05,B1 in address order.
- R10: Status offset 0x00 reads count bits 31:0 and 0x04 reads bits 63:32. The status identification table matches R9, except that the byte at 0xFE0 is BB.
- R11: Status-frame writes and writes to read-only or undecoded control offsets change nothing. Reads of undecoded offsets return 0.
- R12: Read data appears on the frame's rdata in the cycle after the request and is 0 in a cycle after no read.
- R13: `count_o` always shows the current 64-bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count qualifier, one step per high cycle |
| ctl_valid | input | 1 | Control frame request |
| ctl_write | input | 1 | Control request is a write |
| ctl_addr | input | 12 | Control byte offset |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Control read data, registered |
| sts_valid | input | 1 | Status frame request |
| sts_write | input | 1 | Status request is a write (ignored) |
| sts_addr | input | 12 | Status byte offset |
| sts_rdata | output | 32 | Status read data, registered |
| count_o | output | 64 | Current count |

## Verification
The stepping logic is driven three ways: unit steps with idle gaps between ticks, and scaled steps with a half step and with a one-and-a-half step. The half step shows whether the fraction carries at all. The one-and-a-half step separates a carried fraction from one that is truncated or rounded on each tick. Half writes are tried with carry across the 32-bit boundary, with full wraparound, with a tick in the same cycle and with a fraction pending, which separates write priority and fraction clearing from plain stepping. Reads through both frames and of aliased, constant and undecoded offsets show that each decoder selects the right source.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int FW = 24;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_UNIT   = 2'd1,
        ST_SCALED = 2'd2
    } sc_mode_e;

    localparam logic [AW-1:0] OFS_CR     = 12'h000;
    localparam logic [AW-1:0] OFS_SR     = 12'h004;
    localparam logic [AW-1:0] OFS_CV_LO  = 12'h008;
    localparam logic [AW-1:0] OFS_CV_HI  = 12'h00C;
    localparam logic [AW-1:0] OFS_STEP   = 12'h010;
    localparam logic [AW-1:0] OFS_IDREG  = 12'h01C;
    localparam logic [AW-1:0] OFS_STEP0  = 12'h0D0;
    localparam logic [AW-1:0] OFS_STEP1  = 12'h0D4;
    localparam logic [AW-1:0] OFS_ST_LO  = 12'h000;
    localparam logic [AW-1:0] OFS_ST_HI  = 12'h004;
    localparam logic [AW-1:0] OFS_TAB_LO = 12'hFD0;
    localparam logic [AW-1:0] OFS_TAB_HI = 12'hFFC;

    localparam logic [DW-1:0] STEP_ONE   = 32'h0100_0000;
    localparam logic [DW-1:0] IDREG_VAL  = 32'h0002_0001;

    function automatic logic [7:0] id_byte(input logic [3:0] idx, input logic status_frame);
        unique case (idx)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = status_frame ? 8'hBB : 8'hBA;
            4'd5:    id_byte = 8'hB0;
            4'd6:    id_byte = 8'h0B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/sc_ctrl_fsm.sv
module sc_ctrl_fsm
    import sc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cr_wr,
    input  logic [4:0]    cr_wdata,
    output sc_mode_e      mode,
    output logic          step_unit,
    output logic          step_scaled,
    output logic [DW-1:0] cr_word
);
    sc_mode_e   mode_q, mode_d;
    logic [4:1] flags_q;

    always_comb begin
        mode_d = mode_q;
        if (cr_wr) begin
            unique case ({cr_wdata[0], cr_wdata[2]})
                2'b10:   mode_d = ST_UNIT;
                2'b11:   mode_d = ST_SCALED;
                default: mode_d = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= ST_HALT;
        else        mode_q <= mode_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     flags_q <= '0;
        else if (cr_wr) flags_q <= cr_wdata[4:1];
    end

    always_comb begin
        step_unit   = 1'b0;
        step_scaled = 1'b0;
        unique case (mode_q)
            ST_UNIT:   step_unit   = 1'b1;
            ST_SCALED: step_scaled = 1'b1;
            default:   ;
        endcase
        cr_word = {{(DW-5){1'b0}}, flags_q, (mode_q != ST_HALT)};
    end

    assign mode = mode_q;
endmodule

// File: rtl/sc_count.sv
module sc_count
    import sc_pkg::*;
#(
    parameter int HW  = DW,
    parameter int FRW = FW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            step_unit,
    input  logic            step_scaled,
    input  logic [HW-1:0]   step,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [HW-1:0]   wdata,
    output logic [2*HW-1:0] count
);
    localparam int CW = 2 * HW;
    localparam int AccW = CW + FRW;

    logic [CW-1:0]   count_q;
    logic [FRW-1:0]  frac_q;
    logic [AccW-1:0] acc_sum;

    assign acc_sum = {count_q, frac_q} + {{(AccW-HW){1'b0}}, step};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            frac_q  <= '0;
        end else if (wr_lo) begin
            count_q <= {count_q[CW-1:HW], wdata};
            frac_q  <= '0;
        end else if (wr_hi) begin
            count_q <= {wdata, count_q[HW-1:0]};
            frac_q  <= '0;
        end else if (tick && step_scaled) begin
            {count_q, frac_q} <= acc_sum;
        end else if (tick && step_unit) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/sc_rdmux.sv
module sc_rdmux
    import sc_pkg::*;
(
    input  logic [AW-1:0]   ctl_addr,
    input  logic [AW-1:0]   sts_addr,
    input  logic [2*DW-1:0] count,
    input  logic [DW-1:0]   cr_word,
    input  logic [DW-1:0]   step,
    output logic [DW-1:0]   ctl_rd,
    output logic [DW-1:0]   sts_rd
);
    function automatic logic in_table(input logic [AW-1:0] a);
        in_table = (a >= OFS_TAB_LO) && (a <= OFS_TAB_HI) && (a[1:0] == 2'b00);
    endfunction

    always_comb begin
        ctl_rd = '0;
        if (in_table(ctl_addr)) begin
            ctl_rd = {24'h0, id_byte(ctl_addr[5:2] - 4'd4, 1'b0)};
        end else begin
            unique case (ctl_addr)
                OFS_CR:               ctl_rd = cr_word;
                OFS_CV_LO:            ctl_rd = count[DW-1:0];
                OFS_CV_HI:            ctl_rd = count[2*DW-1:DW];
                OFS_STEP, OFS_STEP0:  ctl_rd = step;
                OFS_IDREG:            ctl_rd = IDREG_VAL;
                default:              ctl_rd = '0;
            endcase
        end
    end

    always_comb begin
        sts_rd = '0;
        if (in_table(sts_addr)) begin
            sts_rd = {24'h0, id_byte(sts_addr[5:2] - 4'd4, 1'b1)};
        end else begin
            unique case (sts_addr)
                OFS_ST_LO: sts_rd = count[DW-1:0];
                OFS_ST_HI: sts_rd = count[2*DW-1:DW];
                default:   sts_rd = '0;
            endcase
        end
    end
endmodule

// File: rtl/system_counter.sv
module system_counter
    import sc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ctl_valid,
    input  logic          ctl_write,
    input  logic [11:0]   ctl_addr,
    input  logic [31:0]   ctl_wdata,
    output logic [31:0]   ctl_rdata,
    input  logic          sts_valid,
    input  logic          sts_write,
    input  logic [11:0]   sts_addr,
    output logic [31:0]   sts_rdata,
    output logic [63:0]   count_o
);
    sc_mode_e      mode;
    logic          step_unit, step_scaled;
    logic [DW-1:0] cr_word, step_q, ctl_rd, sts_rd;
    logic          ctl_wr, wr_cr, wr_lo, wr_hi, wr_step;

    assign ctl_wr  = ctl_valid && ctl_write;
    assign wr_cr   = ctl_wr && (ctl_addr == OFS_CR);
    assign wr_lo   = ctl_wr && (ctl_addr == OFS_CV_LO);
    assign wr_hi   = ctl_wr && (ctl_addr == OFS_CV_HI);
    assign wr_step = ctl_wr && ((ctl_addr == OFS_STEP) || (ctl_addr == OFS_STEP0));

    sc_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cr_wr(wr_cr), .cr_wdata(ctl_wdata[4:0]),
        .mode(mode), .step_unit(step_unit), .step_scaled(step_scaled), .cr_word(cr_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       step_q <= STEP_ONE;
        else if (wr_step) step_q <= ctl_wdata;
    end

    sc_count #(.HW(DW), .FRW(FW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .step_unit(step_unit),
        .step_scaled(step_scaled), .step(step_q), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wdata(ctl_wdata), .count(count_o)
    );

    sc_rdmux u_rd (
        .ctl_addr(ctl_addr), .sts_addr(sts_addr), .count(count_o),
        .cr_word(cr_word), .step(step_q), .ctl_rd(ctl_rd), .sts_rd(sts_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_rdata <= '0;
            sts_rdata <= '0;
        end else begin
            ctl_rdata <= (ctl_valid && !ctl_write) ? ctl_rd : '0;
            sts_rdata <= (sts_valid && !sts_write) ? sts_rd : '0;
        end
    end
endmodule

// File: rtl/sc_checker.sv
module sc_checker
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        ctl_valid,
    input logic        ctl_write,
    input logic [11:0] ctl_addr,
    input logic [31:0] ctl_wdata,
    input logic [31:0] ctl_rdata,
    input logic        sts_valid,
    input logic        sts_write,
    input logic [31:0] sts_rdata,
    input logic [63:0] count_o,
    input sc_mode_e    mode,
    input logic [31:0] step_q
);
    logic cnt_wr, step_wr;
    assign cnt_wr  = ctl_valid && ctl_write && (ctl_addr == OFS_CV_LO || ctl_addr == OFS_CV_HI);
    assign step_wr = ctl_valid && ctl_write && (ctl_addr == OFS_STEP || ctl_addr == OFS_STEP0);

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_HALT && !cnt_wr) |=> $stable(count_o)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count_o)); // R4
    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_UNIT && tick && !cnt_wr) |=> (count_o == $past(count_o) + 64'd1)); // R4
    AST_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_write && ctl_addr == OFS_CV_LO) |=> (count_o[31:0] == $past(ctl_wdata))); // R6
    AST_STEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_wr |=> $stable(step_q)); // R7
    AST_CTL_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_valid && !ctl_write) |=> (ctl_rdata == 32'h0)); // R12
    AST_STS_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sts_valid && !sts_write) |=> (sts_rdata == 32'h0)); // R12
endmodule

bind system_counter sc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_valid(ctl_valid), .ctl_write(ctl_write),
    .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .sts_valid(sts_valid),
    .sts_write(sts_write), .sts_rdata(sts_rdata), .count_o(count_o), .mode(mode), .step_q(step_q)
);

// File: tb/tb_system_counter.sv
module tb_system_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        ctl_valid = 1'b0, ctl_write = 1'b0;
    logic [11:0] ctl_addr = '0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        sts_valid = 1'b0, sts_write = 1'b0;
    logic [11:0] sts_addr = '0;
    logic [31:0] sts_rdata;
    logic [63:0] count_o;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    system_counter dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_valid(ctl_valid), .ctl_write(ctl_write),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .sts_valid(sts_valid), .sts_write(sts_write), .sts_addr(sts_addr),
        .sts_rdata(sts_rdata), .count_o(count_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic ctl_wr(input logic [11:0] a, input logic [31:0] d, input logic t = 1'b0);
        @(negedge clk);
        ctl_valid = 1'b1; ctl_write = 1'b1; ctl_addr = a; ctl_wdata = d; tick = t;
        @(negedge clk);
        ctl_valid = 1'b0; ctl_write = 1'b0; tick = 1'b0;
    endtask

    task automatic ctl_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        ctl_valid = 1'b1; ctl_write = 1'b0; ctl_addr = a;
        @(negedge clk);
        ctl_valid = 1'b0;
        d = ctl_rdata;
    endtask

    task automatic sts_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        sts_valid = 1'b1; sts_write = 1'b0; sts_addr = a;
        @(negedge clk);
        sts_valid = 1'b0;
        d = sts_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 count_o", count_o, 64'h0);
        ctl_rd(12'h000, d); chk("R1 control", {32'h0, d}, 64'h0);
        ctl_rd(12'h008, d); chk("R1 count lo", {32'h0, d}, 64'h0);
        ctl_rd(12'h00C, d); chk("R1 count hi", {32'h0, d}, 64'h0);
        ctl_rd(12'h010, d); chk("R1 step", {32'h0, d}, 64'h0100_0000);
    endtask

    task automatic t_ctrl_mask();
        logic [31:0] d;
        ctl_wr(12'h000, 32'hFFFF_FF3E);
        ctl_rd(12'h000, d); chk("R2 masked write", {32'h0, d}, 64'h1E);
        ctl_wr(12'h000, 32'h0000_0000);
        ctl_rd(12'h000, d); chk("R2 cleared", {32'h0, d}, 64'h0);
    endtask

    task automatic t_halt();
        ticks(10);
        chk("R3 halted count", count_o, 64'h0);
    endtask

    task automatic t_unit();
        logic [31:0] d;
        ctl_wr(12'h000, 32'h1);
        ticks(5);
        chk("R4 five unit ticks", count_o, 64'd5);
        repeat (3) @(negedge clk);
        chk("R4 no tick no change", count_o, 64'd5);
        ctl_rd(12'h008, d); chk("R13 count_o matches lo", {32'h0, d}, count_o);
    endtask

    task automatic t_scaled();
        logic [31:0] d;
        ctl_wr(12'h000, 32'h0);
        ctl_wr(12'h008, 32'h0);
        ctl_wr(12'h010, 32'h0080_0000);
        ctl_wr(12'h000, 32'h5);
        ticks(5);
        chk("R5 half step x5", count_o, 64'd2);
        ticks(1);
        chk("R5 half step carry", count_o, 64'd3);
        ctl_wr(12'h0D0, 32'h0180_0000);
        ctl_rd(12'h010, d); chk("R7 alias 0x10", {32'h0, d}, 64'h0180_0000);
        ctl_wr(12'h008, 32'h0);
        ticks(3);
        chk("R5 1.5 step x3", count_o, 64'd4);
    endtask

    task automatic t_count_write();
        ctl_wr(12'h000, 32'h0);
        ctl_wr(12'h00C, 32'h1234_5678);
        chk("R6 hi write keeps lo", count_o, 64'h1234_5678_0000_0004);
        ctl_wr(12'h008, 32'hFFFF_FFFF);
        chk("R6 lo write keeps hi", count_o, 64'h1234_5678_FFFF_FFFF);
        ctl_wr(12'h000, 32'h1);
        ticks(1);
        chk("R4 carry into hi", count_o, 64'h1234_5679_0000_0000);
        ctl_wr(12'h008, 32'h100, 1'b1);
        chk("R6 write beats tick", count_o, 64'h1234_5679_0000_0100);
        ctl_wr(12'h00C, 32'hFFFF_FFFF);
        ctl_wr(12'h008, 32'hFFFF_FFFF);
        ticks(1);
        chk("R6 wraparound", count_o, 64'h0);
        ctl_wr(12'h010, 32'h0080_0000);
        ctl_wr(12'h000, 32'h5);
        ctl_wr(12'h008, 32'h0);
        ticks(1);
        chk("R5 half pending", count_o, 64'h0);
        ctl_wr(12'h008, 32'h10);
        ticks(1);
        chk("R6 fraction cleared", count_o, 64'h10);
        ctl_wr(12'h000, 32'h0);
    endtask

    task automatic t_aux();
        logic [31:0] d;
        ctl_rd(12'h004, d); chk("R7 status reg 0", {32'h0, d}, 64'h0);
        ctl_wr(12'h0D4, 32'hFFFF_FFFF);
        ctl_rd(12'h0D4, d); chk("R7 step1 reads 0", {32'h0, d}, 64'h0);
        ctl_rd(12'h0D0, d); chk("R7 step unchanged", {32'h0, d}, 64'h0080_0000);
        ctl_wr(12'h01C, 32'hFFFF_FFFF);
        ctl_wr(12'h004, 32'hFFFF_FFFF);
        ctl_wr(12'h040, 32'hFFFF_FFFF);
        ctl_rd(12'h01C, d); chk("R8 id register", {32'h0, d}, 64'h0002_0001);
        ctl_rd(12'h004, d); chk("R11 ro status reg", {32'h0, d}, 64'h0);
        ctl_rd(12'h040, d); chk("R11 undecoded ctl", {32'h0, d}, 64'h0);
        ctl_rd(12'h000, d); chk("R11 control intact", {32'h0, d}, 64'h0);
        chk("R11 count intact", count_o, 64'h10);
    endtask

    task automatic t_id();
        logic [7:0] tab [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'hBA, 8'hB0,
                                 8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        logic [31:0] d;
        for (int i = 0; i < 12; i++) begin
            ctl_rd(12'hFD0 + 12'(4 * i), d);
            chk("R9 control id byte", {32'h0, d}, {56'h0, tab[i]});
            sts_rd(12'hFD0 + 12'(4 * i), d);
            chk("R10 status id byte", {32'h0, d}, {56'h0, (i == 4) ? 8'hBB : tab[i]});
        end
    endtask

    task automatic t_status();
        logic [31:0] d;
        ctl_wr(12'h00C, 32'hCAFE_0001);
        sts_rd(12'h000, d); chk("R10 status lo", {32'h0, d}, 64'h10);
        sts_rd(12'h004, d); chk("R10 status hi", {32'h0, d}, 64'hCAFE_0001);
        @(negedge clk);
        sts_valid = 1'b1; sts_write = 1'b1; sts_addr = 12'h000;
        @(negedge clk);
        sts_valid = 1'b0; sts_write = 1'b0;
        chk("R11 status write ignored", count_o, 64'hCAFE_0001_0000_0010);
        sts_rd(12'h020, d); chk("R11 undecoded sts", {32'h0, d}, 64'h0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        ctl_valid = 1'b1; ctl_write = 1'b0; ctl_addr = 12'h01C;
        chk("R12 not yet", {32'h0, ctl_rdata}, 64'h0);
        @(negedge clk);
        ctl_valid = 1'b0;
        chk("R12 next cycle", {32'h0, ctl_rdata}, 64'h0002_0001);
        @(negedge clk);
        chk("R12 back to zero", {32'h0, ctl_rdata}, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_mask();
        t_halt();
        t_unit();
        t_scaled();
        t_count_write();
        t_aux();
        t_id();
        t_status();
        t_latency();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule